// File: doc/BRIEF.md
# Bus Width Adapter with Selectable Piece Order

This block sits on the data path of a 36-bit queue and lets the producer side and the consumer side run at different bus widths. When the consumer side is narrower, each 36-bit word taken in is handed out as two 18-bit or four 9-bit pieces. When the producer side is narrower, 18-bit or 9-bit pieces are gathered into one 36-bit word, which is emitted only once it is complete.

A single order select, sampled with the width configuration while master reset is held, applies to both packing and unpacking. With the big-endian order the most significant piece travels first. With the little-endian order the least significant piece travels first. Both streams use a valid/ready handshake. Narrow data always occupies the low bits of the 36-bit data ports.

Top module: `bus_width_adapter`

## Requirements
- R1: The pins `cfg_pack` and `cfg_width` select the width pair while `mrst` is high. `cfg_width` 00 gives 36 in and 36 out, and `cfg_pack` is then ignored. With `cfg_pack`=0, 01 gives 36 in and 18 out, and 10 gives 36 in and 9 out. With `cfg_pack`=1, 01 gives 18 in and 36 out, and 10 gives 9 in and 36 out. The code 11 behaves as 36 in and 36 out.
- R2: Configuration pins are sampled only on clock edges where `mrst` is high. A change on them at any other time has no effect on the data delivered.
- R3: In the 36/36 pairing each accepted word is delivered unchanged, once, in arrival order.
- R4: When unpacking, each 36-bit word yields exactly 2 pieces (x18) or 4 pieces (x9) on `rd_data[17:0]` or `rd_data[8:0]`, and every `rd_data` bit above the piece width is 0.
- R5: When unpacking with `cfg_big`=1, pieces leave in order from the most significant piece (bits 35 down) to the least significant one.
- R6: When unpacking with `cfg_big`=0, pieces leave in order from the least significant piece (bits 0 up) to the most significant one.
- R7: When packing, a 36-bit word is offered only after all its 2 or 4 pieces have been accepted. The first piece fills the top lane if `cfg_big`=1 and the bottom lane if `cfg_big`=0, and later pieces fill the following lanes in the same direction.
- R8: When packing, `wr_data` bits above the piece width are ignored.
- R9: One clock edge with `mrst` high discards any partly assembled or partly delivered word. Afterwards `rd_valid` is 0 and `wr_ready` is 1.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high; configuration is sampled while high |
| cfg_pack | input | 1 | 1: the narrow bus is on the write side; 0: it is on the read side |
| cfg_width | input | 2 | Narrow width code: 00 none, 01 x18, 10 x9, 11 treated as 00 |
| cfg_big | input | 1 | 1: most significant piece first; 0: least significant first |
| wr_valid | input | 1 | Write-side data valid |
| wr_ready | output | 1 | Write-side ready |
| wr_data | input | 36 | Write data; narrow pieces in the low bits |
| rd_valid | output | 1 | Read-side data valid |
| rd_ready | input | 1 | Read-side ready |
| rd_data | output | 36 | Read data; narrow pieces in the low bits, upper bits zero |

## Verification
The assertions take for granted that `mrst` is high on the first clock edge, so the latched configuration is defined before any property becomes active. They also assume that inputs settle between edges, so a stalled output can be compared with its value one cycle earlier. The bench holds reset from time zero and changes every input one nanosecond after a rising edge. It then scrambles the configuration pins after each reset so that the latched setting is used. It also pulses reset in the middle of traffic, with pieces in flight, in every width pairing.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    typedef enum logic [1:0] {
        RATIO_1 = 2'd0,
        RATIO_2 = 2'd1,
        RATIO_4 = 2'd2
    } ratio_e;

    typedef struct packed {
        logic   pack;
        ratio_e ratio;
        logic   big;
    } cfg_t;

    function automatic logic [1:0] last_idx(input ratio_e r);
        case (r)
            RATIO_2: last_idx = 2'd1;
            RATIO_4: last_idx = 2'd3;
            default: last_idx = 2'd0;
        endcase
    endfunction

    // Lane that the k-th piece in transfer order occupies.
    function automatic logic [1:0] lane_of(input logic [1:0] k, input ratio_e r, input logic big);
        lane_of = big ? (last_idx(r) - k) : k;
    endfunction

endpackage

// File: rtl/bwa_cfg_latch.sv
module bwa_cfg_latch
    import bwa_pkg::*;
(
    input  logic       clk,
    input  logic       mrst,
    input  logic       cfg_pack,
    input  logic [1:0] cfg_width,
    input  logic       cfg_big,
    output cfg_t       cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mrst) begin
            cfg_d.big = cfg_big;
            case (cfg_width)
                2'b01: begin
                    cfg_d.ratio = RATIO_2;
                    cfg_d.pack  = cfg_pack;
                end
                2'b10: begin
                    cfg_d.ratio = RATIO_4;
                    cfg_d.pack  = cfg_pack;
                end
                default: begin
                    cfg_d.ratio = RATIO_1;
                    cfg_d.pack  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (mrst)
        !mrst |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/bwa_lane_select.sv
module bwa_lane_select
    import bwa_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [1:0]        lane_i,
    input  ratio_e            ratio_i,
    output logic [DATA_W-1:0] piece_o
);

    localparam int HALF_W = DATA_W / 2;
    localparam int QUAR_W = DATA_W / 4;

    logic [HALF_W-1:0] half_lane [2];
    logic [QUAR_W-1:0] quar_lane [4];

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign half_lane[g] = word_i[g*HALF_W +: HALF_W];
    end

    for (genvar g = 0; g < 4; g++) begin : g_quar
        assign quar_lane[g] = word_i[g*QUAR_W +: QUAR_W];
    end

    always_comb begin
        piece_o = '0;
        case (ratio_i)
            RATIO_2: piece_o[HALF_W-1:0] = half_lane[lane_i[0]];
            RATIO_4: piece_o[QUAR_W-1:0] = quar_lane[lane_i];
            default: piece_o = word_i;
        endcase
    end

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              cfg_pack,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_big,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HALF_W = DATA_W / 2;
    localparam int QUAR_W = DATA_W / 4;

    typedef struct packed {
        logic              full;
        logic [1:0]        cnt;
        logic [DATA_W-1:0] word;
    } state_t;

    state_t            st_d, st_q;
    cfg_t              cfg;
    logic [DATA_W-1:0] piece;
    logic [1:0]        lane;
    logic              last;
    logic              wr_fire;
    logic              rd_fire;

    bwa_cfg_latch i_cfg (
        .clk      (clk),
        .mrst     (mrst),
        .cfg_pack (cfg_pack),
        .cfg_width(cfg_width),
        .cfg_big  (cfg_big),
        .cfg_o    (cfg)
    );

    bwa_lane_select #(.DATA_W(DATA_W)) i_sel (
        .word_i (st_q.word),
        .lane_i (lane),
        .ratio_i(cfg.ratio),
        .piece_o(piece)
    );

    always_comb begin
        lane     = lane_of(st_q.cnt, cfg.ratio, cfg.big);
        last     = (st_q.cnt == last_idx(cfg.ratio));
        wr_ready = !st_q.full;
        rd_valid = st_q.full;
        rd_data  = cfg.pack ? st_q.word : piece;
        wr_fire  = wr_valid && wr_ready;
        rd_fire  = rd_valid && rd_ready;

        st_d = st_q;
        if (mrst) begin
            st_d = '0;
        end else if (!cfg.pack) begin
            if (wr_fire) begin
                st_d.word = wr_data;
                st_d.full = 1'b1;
                st_d.cnt  = '0;
            end
            if (rd_fire) begin
                if (last) begin
                    st_d.full = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 2'd1;
                end
            end
        end else begin
            if (wr_fire) begin
                case (cfg.ratio)
                    RATIO_2: st_d.word[int'(lane[0])*HALF_W +: HALF_W] = wr_data[HALF_W-1:0];
                    RATIO_4: st_d.word[int'(lane)*QUAR_W +: QUAR_W]    = wr_data[QUAR_W-1:0];
                    default: st_d.word = wr_data;
                endcase
                if (last) begin
                    st_d.full = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 2'd1;
                end
            end
            if (rd_fire) begin
                st_d.full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        mrst |=> !rd_valid && wr_ready); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (mrst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R10

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (mrst)
        rd_valid && !cfg.pack && cfg.ratio == RATIO_4 |-> rd_data[DATA_W-1:QUAR_W] == '0); // R4

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (mrst)
        rd_valid && !cfg.pack && cfg.ratio == RATIO_2 |-> rd_data[DATA_W-1:HALF_W] == '0); // R4

    AST_PACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (mrst)
        cfg.pack && $rose(rd_valid) |-> $past(wr_valid && wr_ready)); // R7

    AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (mrst)
        st_q.cnt <= last_idx(cfg.ratio)); // R4

endmodule

// File: tb/test_bus_width_adapter.sv
`timescale 1ns/1ps
module test_bus_width_adapter;

    logic        clk = 1'b0;
    logic        mrst = 1'b1;
    logic        cfg_pack = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_big = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [35:0] wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [35:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    logic [35:0] exp_q[$];
    int          m_n = 1;
    int          m_w = 36;
    bit          m_pack = 0;
    bit          m_big = 0;
    int          pcnt = 0;
    logic [35:0] pword = '0;
    bit          prev_stall = 0;
    logic [35:0] prev_data = '0;
    int          delivered = 0;
    string       tag = "R1 R2 R3";

    always #2 clk = ~clk;

    bus_width_adapter i_bus_width_adapter (
        .clk(clk), .mrst(mrst), .cfg_pack(cfg_pack), .cfg_width(cfg_width), .cfg_big(cfg_big),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] piece_mask(input int w);
        return (w >= 36) ? 36'hF_FFFF_FFFF : ((36'd1 << w) - 36'd1);
    endfunction

    function automatic int lane_for(input int k);
        return m_big ? (m_n - 1 - k) : k;
    endfunction

    // R1: width pairing derived from the pins during reset
    task automatic load_model();
        if (cfg_width == 2'b01 || cfg_width == 2'b10) begin
            m_n    = (cfg_width == 2'b01) ? 2 : 4;
            m_pack = cfg_pack;
        end else begin
            m_n    = 1;
            m_pack = 0;
        end
        m_w   = 36 / m_n;
        m_big = cfg_big;
        if (m_n == 1)      tag = "R1 R2 R3";
        else if (m_pack)   tag = m_big ? "R2 R7 R8 big" : "R2 R7 R8 little";
        else               tag = m_big ? "R2 R4 R5" : "R2 R4 R6";
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            if (mrst) begin
                load_model();
                exp_q.delete();
                pcnt       = 0;
                pword      = '0;
                prev_stall = 0;
            end else begin
                if (prev_stall) begin
                    check(rd_valid == 1'b1 && rd_data == prev_data, "R10 stall hold", rd_data, prev_data);
                end
                if (rd_valid && rd_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, {tag, " unexpected output"}, rd_data, '0);
                    end else begin
                        check(rd_data === exp_q[0], tag, rd_data, exp_q[0]);
                        void'(exp_q.pop_front());
                        delivered++;
                    end
                end
                if (wr_valid && wr_ready) begin
                    if (!m_pack) begin
                        for (int k = 0; k < m_n; k++) begin
                            exp_q.push_back((wr_data >> (lane_for(k) * m_w)) & piece_mask(m_w));
                        end
                    end else begin
                        pword = pword | ((wr_data & piece_mask(m_w)) << (lane_for(pcnt) * m_w));
                        pcnt++;
                        if (pcnt == m_n) begin
                            exp_q.push_back(pword);
                            pword = '0;
                            pcnt  = 0;
                        end
                    end
                end
                prev_stall = rd_valid && !rd_ready;
                prev_data  = rd_data;
            end
        end
    end

    task automatic do_reset(input bit p, input logic [1:0] w, input bit b);
        @(posedge clk); #1;
        mrst      = 1'b1;
        cfg_pack  = p;
        cfg_width = w;
        cfg_big   = b;
        wr_valid  = 1'b0;
        rd_ready  = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        mrst = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R9 rd_valid after reset", {35'd0, rd_valid}, 36'd0);
        check(wr_ready == 1'b1, "R9 wr_ready after reset", {35'd0, wr_ready}, 36'd1);
    endtask

    task automatic traffic(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            logic [63:0] r;
            @(posedge clk); #1;
            r         = {$urandom(), $urandom()};
            wr_data   = r[35:0];
            wr_valid  = ($urandom_range(0, 9) < 7);
            rd_ready  = ($urandom_range(0, 9) < 6);
            // R2: pins move freely outside reset
            cfg_pack  = $urandom_range(0, 1);
            cfg_width = 2'($urandom_range(0, 3));
            cfg_big   = $urandom_range(0, 1);
        end
    endtask

    task automatic drain();
        @(posedge clk); #1;
        wr_valid = 1'b0;
        rd_ready = 1'b1;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, {tag, " all expected data delivered"}, 36'(exp_q.size()), 36'd0);
    endtask

    task automatic run_phase(input bit p, input logic [1:0] w, input bit b);
        delivered = 0;
        do_reset(p, w, b);
        traffic(150);
        // R9: reset in the middle of traffic with pieces in flight
        do_reset(p, w, b);
        traffic(150);
        drain();
        check(delivered > 20, {tag, " outputs observed"}, 36'(delivered), 36'd21);
    endtask

    initial begin
        run_phase(1'b0, 2'b00, 1'b0);   // 36/36
        run_phase(1'b0, 2'b01, 1'b1);   // 36/18 big
        run_phase(1'b0, 2'b01, 1'b0);   // 36/18 little
        run_phase(1'b0, 2'b10, 1'b1);   // 36/9 big
        run_phase(1'b0, 2'b10, 1'b0);   // 36/9 little
        run_phase(1'b1, 2'b01, 1'b1);   // 18/36 big
        run_phase(1'b1, 2'b01, 1'b0);   // 18/36 little
        run_phase(1'b1, 2'b10, 1'b1);   // 9/36 big
        run_phase(1'b1, 2'b10, 1'b0);   // 9/36 little
        run_phase(1'b0, 2'b11, 1'b1);   // R1 illegal code -> 36/36
        run_phase(1'b1, 2'b00, 1'b1);   // R1 pack ignored at full width
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule